// File: doc/BRIEF.md
# Multi-Context Error Location Scheduler

This block sits in front of one shared error-location decoding engine and keeps eight independent syndrome contexts. Software writes a syndrome word into a context and then marks that context valid. The scheduler picks valid contexts one at a time in round-robin order and starts the engine on each. When the engine reports back, the scheduler stores that context's error count, uncorrectable flag and error locations. It also sets a sticky per-context done bit.

A single interrupt line tells the host when results can be read. There are two policies. In page mode one interrupt stands once every context named in a page enable mask has finished. In continuous mode every finished context whose mask bit is set raises the line. Results are read through an index-selected read port. Done bits are cleared by writing ones.

Top module: `errloc_sched`

## Requirements
- R1: After reset, no context is valid or done, the engine is not busy, no start is issued, the mode is page mode (mode value 0), and the interrupt line is low.
- R2: When a context is started, `eng_syn_o` carries the syndrome last written to that context and `eng_ctx_o` carries its index.
- R3: Valid contexts are served in round-robin order, beginning with the index after the one served last. The first context served after reset is searched from index 0.
- R4: Only one context is in the engine at a time. A start is a one-cycle pulse on `eng_start_o`. An `eng_done_i` pulse while busy stores the engine's location words for the current context, readable at `rd_loc_o` when `rd_idx_i` selects it.
- R5: A result reports either an error count or an uncorrectable mark. When `eng_unc_i` is 1, the stored count reads 0 and `rd_unc_o` reads 1. Otherwise the stored count equals `eng_cnt_i` and `rd_unc_o` reads 0.
- R6: A context's done bit is set when its result is stored and stays set until a 1 is written to its bit of `done_clr_i`. Other done bits are unaffected by that write. A set and a clear in the same cycle leave the bit set.
- R7: In continuous mode (mode value 1), `irq_o` is the OR over contexts of done AND `irq_mask_i`.
- R8: In page mode, `irq_o` is high exactly when the page mask is nonzero and every context whose page mask bit is 1 is done.
- R9: Setting valid for the context currently in the engine has no effect. Its valid bit stays 0 and it is not served again.
- R10: A mode write takes effect only when no context is valid and the engine is idle. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| syn_we_i | input | 1 | Syndrome write strobe |
| syn_idx_i | input | 3 | Context written by `syn_we_i` |
| syn_data_i | input | 16 | Syndrome word |
| valid_set_i | input | 8 | One bit per context: mark valid |
| done_clr_i | input | 8 | One bit per context: clear done (write one) |
| mode_we_i | input | 1 | Mode write strobe |
| mode_val_i | input | 1 | 0 page mode, 1 continuous mode |
| page_mask_we_i | input | 1 | Page mask write strobe |
| page_mask_i | input | 8 | Contexts belonging to the page |
| irq_mask_i | input | 8 | Continuous-mode interrupt enables |
| rd_idx_i | input | 3 | Context selected on the read port |
| eng_start_o | output | 1 | Engine start pulse |
| eng_ctx_o | output | 3 | Context in the engine |
| eng_syn_o | output | 16 | Syndrome of that context |
| eng_done_i | input | 1 | Engine result strobe |
| eng_cnt_i | input | 5 | Engine error count |
| eng_unc_i | input | 1 | Engine uncorrectable flag |
| eng_loc_i | input | 52 | Four 13-bit error locations |
| rd_cnt_o | output | 5 | Stored count of the selected context |
| rd_unc_o | output | 1 | Stored uncorrectable flag |
| rd_loc_o | output | 52 | Stored locations |
| done_o | output | 8 | Sticky done bits |
| valid_o | output | 8 | Valid (waiting) bits |
| busy_o | output | 1 | Engine holds a context |
| mode_o | output | 1 | Current mode |
| irq_o | output | 1 | Interrupt line |

## Verification
`valid_o` follows `valid_set_i` one edge later. An idle scheduler issues `eng_start_o` on the following edge, so a start is seen two edges after the valid write. An `eng_done_i` pulse makes `done_o`, the stored results and `irq_o` visible after the next edge, since the interrupt is combinational from the done bits. Mode and mask writes land one edge after their strobe. The bench drives on falling edges and samples on later falling edges. Where the engine's latency sets the timing, it polls falling edges until the scheduler is idle before comparing. The service order is logged at each start pulse and compared afterwards.

// File: rtl/errloc_pkg.sv
package errloc_pkg;

  localparam int unsigned ERR_CNT_W = 5;

  typedef enum logic {
    MODE_PAGE = 1'b0,
    MODE_CONT = 1'b1
  } sched_mode_e;

  // Count kept for a context: zero when the engine marks it uncorrectable.
  function automatic logic [ERR_CNT_W-1:0] kept_count(input logic unc,
                                                      input logic [ERR_CNT_W-1:0] cnt);
    return unc ? '0 : cnt;
  endfunction

endpackage

// File: rtl/errloc_rr_arb.sv
module errloc_rr_arb #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  // Search starts one past the last served index and wraps around.
  function automatic logic [IW:0] pick(input logic [N-1:0] req,
                                       input logic [IW-1:0] last);
    logic [IW:0] res;
    res = '0;
    for (int k = 1; k <= int'(N); k++) begin
      int unsigned j;
      j = (int'(last) + k) % N;
      if (!res[IW] && req[j]) res = {1'b1, IW'(j)};
    end
    return res;
  endfunction

  logic [IW:0] sel;
  assign sel   = pick(req_i, last_i);
  assign any_o = sel[IW];
  assign idx_o = sel[IW-1:0];

endmodule

// File: rtl/errloc_ctx_bank.sv
module errloc_ctx_bank import errloc_pkg::*; #(
  parameter int unsigned N     = 8,
  parameter int unsigned SYN_W = 16,
  parameter int unsigned CNT_W = ERR_CNT_W,
  parameter int unsigned LOC_W = 13,
  parameter int unsigned NLOC  = 4,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned LW = NLOC * LOC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syn_we_i,
  input  logic [IW-1:0]    syn_idx_i,
  input  logic [SYN_W-1:0] syn_data_i,
  input  logic             res_we_i,
  input  logic [IW-1:0]    res_idx_i,
  input  logic [CNT_W-1:0] res_cnt_i,
  input  logic             res_unc_i,
  input  logic [LW-1:0]    res_loc_i,
  input  logic [N-1:0]     done_clr_i,
  input  logic [IW-1:0]    eng_idx_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [SYN_W-1:0] eng_syn_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             rd_unc_o,
  output logic [LW-1:0]    rd_loc_o,
  output logic [N-1:0]     done_o
);

  logic [SYN_W-1:0] syn_q [N];
  logic [CNT_W-1:0] cnt_q [N];
  logic             unc_q [N];
  logic [LW-1:0]    loc_q [N];
  logic [N-1:0]     done_q;

  for (genvar i = 0; i < int'(N); i++) begin : g_ctx
    logic hit_syn, hit_res;
    assign hit_syn = syn_we_i && (syn_idx_i == IW'(i));
    assign hit_res = res_we_i && (res_idx_i == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        syn_q[i]  <= '0;
        cnt_q[i]  <= '0;
        unc_q[i]  <= 1'b0;
        loc_q[i]  <= '0;
        done_q[i] <= 1'b0;
      end else begin
        if (hit_syn) syn_q[i] <= syn_data_i;
        if (hit_res) begin
          cnt_q[i]  <= kept_count(res_unc_i, res_cnt_i);
          unc_q[i]  <= res_unc_i;
          loc_q[i]  <= res_loc_i;
          done_q[i] <= 1'b1;
        end else if (done_clr_i[i]) begin
          done_q[i] <= 1'b0;
        end
      end
    end
  end

  assign eng_syn_o = syn_q[eng_idx_i];
  assign rd_cnt_o  = cnt_q[rd_idx_i];
  assign rd_unc_o  = unc_q[rd_idx_i];
  assign rd_loc_o  = loc_q[rd_idx_i];
  assign done_o    = done_q;

endmodule

// File: rtl/errloc_irq.sv
module errloc_irq import errloc_pkg::*; #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_we_i,
  input  logic         mode_val_i,
  input  logic         idle_i,
  input  logic         page_mask_we_i,
  input  logic [N-1:0] page_mask_i,
  input  logic [N-1:0] irq_mask_i,
  input  logic [N-1:0] done_i,
  output logic         mode_o,
  output logic [N-1:0] page_mask_o,
  output logic         irq_o
);

  function automatic logic page_complete(input logic [N-1:0] mask,
                                         input logic [N-1:0] done);
    return (mask != '0) && ((done & mask) == mask);
  endfunction

  sched_mode_e  mode_q;
  logic [N-1:0] page_mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_PAGE;
      page_mask_q <= '0;
    end else begin
      if (mode_we_i && idle_i) mode_q <= sched_mode_e'(mode_val_i);
      if (page_mask_we_i)      page_mask_q <= page_mask_i;
    end
  end

  logic page_pend, cont_pend;
  assign page_pend = page_complete(page_mask_q, done_i);
  assign cont_pend = |(done_i & irq_mask_i);

  assign irq_o       = (mode_q == MODE_CONT) ? cont_pend : page_pend;
  assign mode_o      = mode_q;
  assign page_mask_o = page_mask_q;

endmodule

// File: rtl/errloc_sched.sv
module errloc_sched import errloc_pkg::*; #(
  parameter int unsigned N     = 8,
  parameter int unsigned SYN_W = 16,
  parameter int unsigned CNT_W = ERR_CNT_W,
  parameter int unsigned LOC_W = 13,
  parameter int unsigned NLOC  = 4,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned LW = NLOC * LOC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syn_we_i,
  input  logic [IW-1:0]    syn_idx_i,
  input  logic [SYN_W-1:0] syn_data_i,
  input  logic [N-1:0]     valid_set_i,
  input  logic [N-1:0]     done_clr_i,
  input  logic             mode_we_i,
  input  logic             mode_val_i,
  input  logic             page_mask_we_i,
  input  logic [N-1:0]     page_mask_i,
  input  logic [N-1:0]     irq_mask_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic             eng_start_o,
  output logic [IW-1:0]    eng_ctx_o,
  output logic [SYN_W-1:0] eng_syn_o,
  input  logic             eng_done_i,
  input  logic [CNT_W-1:0] eng_cnt_i,
  input  logic             eng_unc_i,
  input  logic [LW-1:0]    eng_loc_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             rd_unc_o,
  output logic [LW-1:0]    rd_loc_o,
  output logic [N-1:0]     done_o,
  output logic [N-1:0]     valid_o,
  output logic             busy_o,
  output logic             mode_o,
  output logic             irq_o
);

  logic [N-1:0]  valid_q;
  logic          busy_q, start_q;
  logic [IW-1:0] cur_q, last_q;

  // Named internal events
  logic          arb_any;
  logic [IW-1:0] arb_idx;
  logic          grant_fire;
  logic          eng_accept;
  logic          sched_idle;
  logic [N-1:0]  valid_block;
  logic [N-1:0]  grant_clear;
  logic [N-1:0]  page_mask_w;

  errloc_rr_arb #(.N(N)) u_arb (
    .req_i  (valid_q),
    .last_i (last_q),
    .any_o  (arb_any),
    .idx_o  (arb_idx)
  );

  assign grant_fire  = !busy_q && arb_any;
  assign eng_accept  = busy_q && eng_done_i;
  assign sched_idle  = !busy_q && (valid_q == '0);
  assign valid_block = busy_q ? (N'(1) << cur_q) : '0;
  assign grant_clear = grant_fire ? (N'(1) << arb_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cur_q   <= '0;
      last_q  <= IW'(N - 1);
    end else begin
      start_q <= grant_fire;
      valid_q <= (valid_q | (valid_set_i & ~valid_block)) & ~grant_clear;
      if (grant_fire) begin
        busy_q <= 1'b1;
        cur_q  <= arb_idx;
        last_q <= arb_idx;
      end else if (eng_accept) begin
        busy_q <= 1'b0;
      end
    end
  end

  errloc_ctx_bank #(
    .N(N), .SYN_W(SYN_W), .CNT_W(CNT_W), .LOC_W(LOC_W), .NLOC(NLOC)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .syn_we_i   (syn_we_i),
    .syn_idx_i  (syn_idx_i),
    .syn_data_i (syn_data_i),
    .res_we_i   (eng_accept),
    .res_idx_i  (cur_q),
    .res_cnt_i  (eng_cnt_i),
    .res_unc_i  (eng_unc_i),
    .res_loc_i  (eng_loc_i),
    .done_clr_i (done_clr_i),
    .eng_idx_i  (cur_q),
    .rd_idx_i   (rd_idx_i),
    .eng_syn_o  (eng_syn_o),
    .rd_cnt_o   (rd_cnt_o),
    .rd_unc_o   (rd_unc_o),
    .rd_loc_o   (rd_loc_o),
    .done_o     (done_o)
  );

  errloc_irq #(.N(N)) u_irq (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_we_i      (mode_we_i),
    .mode_val_i     (mode_val_i),
    .idle_i         (sched_idle),
    .page_mask_we_i (page_mask_we_i),
    .page_mask_i    (page_mask_i),
    .irq_mask_i     (irq_mask_i),
    .done_i         (done_o),
    .mode_o         (mode_o),
    .page_mask_o    (page_mask_w),
    .irq_o          (irq_o)
  );

  assign eng_start_o = start_q;
  assign eng_ctx_o   = cur_q;
  assign valid_o     = valid_q;
  assign busy_o      = busy_q;

endmodule

// File: rtl/errloc_sched_chk.sv
module errloc_sched_chk #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_start_o,
  input logic [IW-1:0] eng_ctx_o,
  input logic          busy_o,
  input logic [N-1:0]  valid_o,
  input logic [N-1:0]  valid_set_i,
  input logic [N-1:0]  done_o,
  input logic [N-1:0]  irq_mask_i,
  input logic [N-1:0]  page_mask_w,
  input logic          eng_accept,
  input logic          mode_o,
  input logic          irq_o
);

  // R4: a start lasts one cycle and only with the engine held
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> busy_o);

  // R3: a served context is no longer waiting
  p_grant_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> !valid_o[eng_ctx_o]);

  // R6: an accepted result leaves the context done
  p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_accept |=> done_o[$past(eng_ctx_o)]);

  // R7: continuous interrupt needs an enabled done context
  p_cont_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && irq_o) |-> ((done_o & irq_mask_i) != '0));

  // R8: page interrupt needs the whole page done
  p_page_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && irq_o) |-> (page_mask_w != '0 && (done_o & page_mask_w) == page_mask_w));

  // R9: re-marking the context in the engine does not make it wait
  p_revalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !eng_accept && valid_set_i[eng_ctx_o]) |=> !valid_o[$past(eng_ctx_o)]);

  // R10: mode holds while work is outstanding
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || valid_o != '0) |=> (mode_o == $past(mode_o)));

endmodule

bind errloc_sched errloc_sched_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eng_start_o (eng_start_o),
  .eng_ctx_o   (eng_ctx_o),
  .busy_o      (busy_o),
  .valid_o     (valid_o),
  .valid_set_i (valid_set_i),
  .done_o      (done_o),
  .irq_mask_i  (irq_mask_i),
  .page_mask_w (page_mask_w),
  .eng_accept  (eng_accept),
  .mode_o      (mode_o),
  .irq_o       (irq_o)
);

// File: tb/errloc_sched_test.sv
module errloc_sched_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        syn_we_i = 1'b0;
  logic [2:0]  syn_idx_i = '0;
  logic [15:0] syn_data_i = '0;
  logic [7:0]  valid_set_i = '0;
  logic [7:0]  done_clr_i = '0;
  logic        mode_we_i = 1'b0;
  logic        mode_val_i = 1'b0;
  logic        page_mask_we_i = 1'b0;
  logic [7:0]  page_mask_i = '0;
  logic [7:0]  irq_mask_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic        eng_start_o;
  logic [2:0]  eng_ctx_o;
  logic [15:0] eng_syn_o;
  logic        eng_done_i;
  logic [4:0]  eng_cnt_i;
  logic        eng_unc_i;
  logic [51:0] eng_loc_i;
  logic [4:0]  rd_cnt_o;
  logic        rd_unc_o;
  logic [51:0] rd_loc_o;
  logic [7:0]  done_o, valid_o;
  logic        busy_o, mode_o, irq_o;

  always #10 clk = ~clk;  // 50 MHz

  errloc_sched uut (.*);

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural engine: latches the syndrome at start, answers three cycles later
  function automatic logic [51:0] loc_of(input logic [15:0] s);
    return {s[12:0], s[12:0] + 13'd1, s[12:0] ^ 13'h0AAA, ~s[12:0]};
  endfunction

  logic [15:0] tb_syn [8];
  logic [15:0] lat_syn = '0;
  logic [2:0]  lat = '0;
  logic        eng_busy = 1'b0;
  logic        eng_done_q = 1'b0;
  int          order_log [64];
  bit          synok_log [64];
  int          nstart = 0;

  assign eng_done_i = eng_done_q;
  assign eng_cnt_i  = lat_syn[4:0];
  assign eng_unc_i  = lat_syn[15];
  assign eng_loc_i  = loc_of(lat_syn);

  always @(posedge clk) begin
    eng_done_q <= 1'b0;
    if (eng_start_o) begin
      lat_syn  <= eng_syn_o;
      lat      <= 3'd3;
      eng_busy <= 1'b1;
      if (nstart < 64) begin
        order_log[nstart] = int'(eng_ctx_o);
        synok_log[nstart] = (eng_syn_o == tb_syn[eng_ctx_o]);
      end
      nstart++;
    end else if (eng_busy) begin
      if (lat == 3'd1) begin
        eng_done_q <= 1'b1;
        eng_busy   <= 1'b0;
      end
      lat <= lat - 3'd1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic load(input int idx, input logic [15:0] s);
    @(negedge clk);
    syn_we_i = 1'b1; syn_idx_i = 3'(idx); syn_data_i = s; tb_syn[idx] = s;
    @(negedge clk);
    syn_we_i = 1'b0;
  endtask

  task automatic mark(input logic [7:0] m);
    @(negedge clk);
    valid_set_i = m;
    @(negedge clk);
    valid_set_i = '0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || valid_o != 0 || eng_busy || eng_done_q) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    done_clr_i = 8'hFF;
    @(negedge clk);
    done_clr_i = '0;
  endtask

  task automatic t_reset();
    chk(done_o == 0 && valid_o == 0, "R1 done/valid", {done_o, valid_o}, 0);
    chk(!busy_o && !eng_start_o, "R1 busy/start", {busy_o, eng_start_o}, 0);
    chk(mode_o == 1'b0 && irq_o == 1'b0, "R1 mode/irq", {mode_o, irq_o}, 0);
  endtask

  task automatic t_round_robin();
    int exp_a [4] = '{0, 2, 5, 7};
    for (int i = 0; i < 8; i++) load(i, 16'(16'h0100 * i + i + 1));
    nstart = 0;
    mark(8'hA5);
    wait_idle();
    chk(nstart == 4, "R3 count", nstart, 4);
    for (int i = 0; i < 4; i++) begin
      chk(order_log[i] == exp_a[i], "R3 order first pass", order_log[i], exp_a[i]);
      chk(synok_log[i], "R2 syndrome at start", synok_log[i], 1);
    end
    nstart = 0;
    mark(8'h0A);
    wait_idle();
    chk(order_log[0] == 1 && order_log[1] == 3, "R3 order second pass",
        order_log[0] * 10 + order_log[1], 13);
    nstart = 0;
    mark(8'h42);
    wait_idle();
    chk(order_log[0] == 6 && order_log[1] == 1, "R3 wrap after last served",
        order_log[0] * 10 + order_log[1], 61);
    chk(done_o == 8'hEF, "R6 done bits", done_o, 8'hEF);
    for (int i = 0; i < 8; i++) begin
      if (i == 4) continue;
      rd_idx_i = 3'(i);
      #1;
      chk(rd_cnt_o == 5'(i + 1) && !rd_unc_o, "R5 count", rd_cnt_o, i + 1);
      chk(rd_loc_o == loc_of(tb_syn[i]), "R4 locations", rd_loc_o, loc_of(tb_syn[i]));
    end
  endtask

  task automatic t_uncorrectable();
    load(4, 16'h8007);
    mark(8'h10);
    wait_idle();
    rd_idx_i = 3'd4;
    #1;
    chk(rd_cnt_o == 0 && rd_unc_o, "R5 uncorrectable", {rd_unc_o, rd_cnt_o}, 6'h20);
  endtask

  task automatic t_clear();
    @(negedge clk);
    done_clr_i = 8'h10;
    @(negedge clk);
    done_clr_i = '0;
    chk(done_o == 8'hEF, "R6 one-bit clear", done_o, 8'hEF);
    clear_all();
    chk(done_o == 0, "R6 clear all", done_o, 0);
    // Clear in the same cycle as the result store
    mark(8'h20);
    @(negedge clk);
    while (!eng_done_i) @(negedge clk);
    done_clr_i = 8'h20;
    @(negedge clk);
    done_clr_i = '0;
    chk(done_o[5], "R6 set wins over clear", done_o[5], 1);
    wait_idle();
    clear_all();
  endtask

  task automatic t_page();
    bit seen_low;
    seen_low = 0;
    @(negedge clk);
    page_mask_we_i = 1'b1; page_mask_i = 8'h0F;
    @(negedge clk);
    page_mask_we_i = 1'b0;
    mark(8'h0F);
    while (done_o != 8'h0F) begin
      if (done_o[2] && !seen_low) begin
        seen_low = 1;
        chk(!irq_o, "R8 irq low before page end", irq_o, 0);
      end
      @(negedge clk);
    end
    chk(irq_o, "R8 irq at page end", irq_o, 1);
    wait_idle();
    @(negedge clk);
    done_clr_i = 8'h01;
    @(negedge clk);
    done_clr_i = '0;
    chk(!irq_o, "R8 irq drops when page incomplete", irq_o, 0);
    clear_all();
    @(negedge clk);
    page_mask_we_i = 1'b1; page_mask_i = 8'h00;
    @(negedge clk);
    page_mask_we_i = 1'b0;
  endtask

  task automatic t_mode_and_cont();
    mark(8'h01);
    mode_we_i = 1'b1; mode_val_i = 1'b1;
    @(negedge clk);
    mode_we_i = 1'b0;
    @(negedge clk);
    chk(mode_o == 1'b0, "R10 mode write ignored while busy", mode_o, 0);
    wait_idle();
    clear_all();
    @(negedge clk);
    mode_we_i = 1'b1; mode_val_i = 1'b1;
    @(negedge clk);
    mode_we_i = 1'b0;
    chk(mode_o == 1'b1, "R10 mode write accepted when idle", mode_o, 1);
    irq_mask_i = 8'h30;
    nstart = 0;
    mark(8'h11);
    @(negedge clk);
    while (!done_o[4]) @(negedge clk);
    chk(order_log[0] == 4, "R3 order in continuous mode", order_log[0], 4);
    chk(irq_o, "R7 irq after masked-in context", irq_o, 1);
    wait_idle();
    @(negedge clk);
    done_clr_i = 8'h10;
    @(negedge clk);
    done_clr_i = '0;
    chk(done_o == 8'h01 && !irq_o, "R7 masked-out done gives no irq",
        {irq_o, done_o}, 9'h001);
    clear_all();
  endtask

  task automatic t_revalid();
    int starts2;
    nstart = 0;
    mark(8'h04);
    while (!busy_o) @(negedge clk);
    valid_set_i = 8'h04;
    @(negedge clk);
    valid_set_i = '0;
    chk(!valid_o[2], "R9 re-mark while busy ignored", valid_o[2], 0);
    wait_idle();
    starts2 = 0;
    for (int i = 0; i < nstart; i++) if (order_log[i] == 2) starts2++;
    chk(starts2 == 1 && valid_o == 0, "R9 served once", starts2, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_uncorrectable();
    t_clear();
    t_page();
    t_mode_and_cont();
    t_revalid();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule